// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Arbiter

This block decides which maskable interrupt source a small CPU takes next, and when it takes it. Each source has a sticky request flag, a mask bit and a 2-bit priority code. A global enable flag gates maskable acceptance. A 2-bit in-service code records which priority band is running. Nested servicing is allowed only after software sets the enable flag again, and only for a request of equal or better priority than the band in service.

Every acknowledge saves the current in-service code and enable flag on a four-entry context stack. It then clears enable. A maskable acknowledge also moves the in-service code to the winner's band. A return strobe pops the stack and restores both values. After any return, maskable acceptance waits until one main-program instruction has retired. A software interrupt request takes a separate path. It ignores enable, priority and the post-return wait, and it leaves the in-service code alone.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, ie_o is 0, isp_o is 2'b11 (idle), pend_o is all zero, and ack_o and ack_swi_o are 0.
- R2: Priority code 2'b00 is the most urgent and 2'b11 the least. A maskable acknowledge sets isp_o from the winner's code: 00 or 01 gives 2'b00, 10 gives 2'b01, 11 gives 2'b10. The code 2'b11 means nothing is in service.
- R3: A request pulse on req_i sets the source's pend_o bit at the next edge. An eligible pending flag produces a one-cycle ack_o with ack_id_o at the following edge. At that same edge, ie_o goes to 0 and the winner's pend_o bit clears.
- R4: No maskable acknowledge is issued while ie_o is 0. ei_i sets ie_o and di_i clears it, with ei_i taking precedence.
- R5: With ie_o set, a request is accepted only if its code is at or above the band in service. For isp_o 2'b00 the limit is codes 00 and 01, for 2'b01 it is up to 10, and for 2'b10 or 2'b11 any code is accepted.
- R6: A request that is not accepted keeps its pend_o bit until it is acknowledged or cleared through clr_i.
- R7: After a reti_i strobe, no maskable acknowledge is issued until a retire_i strobe has been seen in a later cycle.
- R8: Among eligible requests with the same best code, the lowest-numbered source wins.
- R9: A source with its mask_i bit set takes no part in arbitration, but its pend_o bit stays set. Once unmasked, it competes normally.
- R10: swi_i latches a software request that is acknowledged with ack_swi_o regardless of ie_o, priority or the post-return wait. It saves the context and clears ie_o but leaves isp_o unchanged. It wins over a maskable request in the same cycle.
- R11: The context stack holds four entries. While it is full, neither kind of acknowledge is issued, and the requests stay pending.
- R12: reti_i restores the most recently saved isp_o and ie_o. On an empty stack it changes neither of them. No acknowledge is issued in a cycle in which reti_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Request pulses, one per source |
| clr_i | input | N_SRC | Software clear of pending flags |
| mask_i | input | N_SRC | 1 excludes the source from arbitration |
| prio_i | input | 2*N_SRC | Priority code per source, source i at bits [2i+1:2i] |
| swi_i | input | 1 | Software interrupt request strobe |
| ei_i | input | 1 | Set global enable strobe |
| di_i | input | 1 | Clear global enable strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retire_i | input | 1 | Main-program instruction retired strobe |
| ack_o | output | 1 | Maskable acknowledge pulse |
| ack_swi_o | output | 1 | Software interrupt acknowledge pulse |
| ack_id_o | output | $clog2(N_SRC) | Source index of the last maskable acknowledge |
| ie_o | output | 1 | Global enable flag |
| isp_o | output | 2 | In-service band code |
| pend_o | output | N_SRC | Pending request flags |

## Verification
The hardest state to reach is a full context stack while requests of mixed urgency are pending. At the same time, the post-return wait must be armed and a software request must collide with a maskable one. Directed scenarios build the stack to depth four with top-urgency sources and re-enable between each nest. They then unwind with returns and withhold the retire strobe. A long random phase follows with sparse return and retire strobes and a high enable rate, so deep nesting and unwinding recur. A behavioural model is compared on every clock throughout.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef logic [1:0] prio_t;
  typedef logic [1:0] isp_t;

  localparam isp_t ISP_IDLE = 2'b11;

  typedef struct packed {
    isp_t isp;
    logic ie;
  } ctx_t;

  function automatic isp_t isp_from_prio(prio_t p);
    case (p)
      2'd0, 2'd1: return 2'b00;
      2'd2:       return 2'b01;
      default:    return 2'b10;
    endcase
  endfunction

  // least urgent code still accepted in a given in-service band
  function automatic prio_t prio_ceiling(isp_t s);
    case (s)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] flag_o
);
  logic [N_SRC-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q | set_i) & ~clr_i & ~ack_clr_i;
  end

  assign flag_o = flag_q;

  AST_ACK_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr_i != '0) |=> ((flag_q & $past(ack_clr_i)) == '0)); // R3
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   flag_i,
  input  logic [N_SRC-1:0]   mask_i,
  input  logic [2*N_SRC-1:0] prio_i,
  input  prio_t              ceil_i,
  output logic               valid_o,
  output logic [IW-1:0]      idx_o,
  output prio_t              prio_o
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = flag_i[g] & ~mask_i[g] & (prio_i[2*g +: 2] <= ceil_i);
  end

  // strict compare in ascending order keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = 2'd3;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!valid_o || prio_i[2*i +: 2] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[2*i +: 2];
      end
    end
  end

  AST_WIN_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_i[idx_o] && !mask_i[idx_o])); // R9
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  m_valid_i,
  input  prio_t m_prio_i,
  input  logic  swi_pend_i,
  input  logic  ei_i,
  input  logic  di_i,
  input  logic  reti_i,
  input  logic  retire_i,
  output logic  grant_m_o,
  output logic  grant_s_o,
  output logic  ie_o,
  output isp_t  isp_o,
  output prio_t ceil_o
);
  ctx_t          stk_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          ie_q, hold_q;
  isp_t          isp_q;
  logic          full, push, pop;
  logic [AW-1:0] wr_idx, rd_idx;

  assign full      = (cnt_q == CW'(DEPTH));
  assign grant_s_o = swi_pend_i & ~full & ~reti_i;
  assign grant_m_o = ~grant_s_o & m_valid_i & ie_q & ~hold_q & ~reti_i & ~full;
  assign push      = grant_m_o | grant_s_o;
  assign pop       = ~push & reti_i & (cnt_q != '0);
  assign wr_idx    = AW'(cnt_q);
  assign rd_idx    = AW'(cnt_q - CW'(1));

  always_ff @(posedge clk_i) begin
    if (push) stk_q[wr_idx] <= '{isp: isp_q, ie: ie_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ie_q   <= 1'b0;
      isp_q  <= ISP_IDLE;
      hold_q <= 1'b0;
    end else begin
      if (reti_i)        hold_q <= 1'b1;
      else if (retire_i) hold_q <= 1'b0;
      if (push) begin
        cnt_q <= cnt_q + CW'(1);
        ie_q  <= 1'b0;
        if (grant_m_o) isp_q <= isp_from_prio(m_prio_i);
      end else if (pop) begin
        cnt_q <= cnt_q - CW'(1);
        ie_q  <= stk_q[rd_idx].ie;
        isp_q <= stk_q[rd_idx].isp;
      end else if (ei_i) begin
        ie_q <= 1'b1;
      end else if (di_i) begin
        ie_q <= 1'b0;
      end
    end
  end

  assign ie_o   = ie_q;
  assign isp_o  = isp_q;
  assign ceil_o = prio_ceiling(isp_q);

  AST_STACK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R11
  AST_GRANT_CLEARS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_m_o || grant_s_o) |=> !ie_q); // R3
  AST_RETI_ARMS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !grant_m_o); // R7
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DEPTH = 4,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [N_SRC-1:0]   clr_i,
  input  logic [N_SRC-1:0]   mask_i,
  input  logic [2*N_SRC-1:0] prio_i,
  input  logic               swi_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               reti_i,
  input  logic               retire_i,
  output logic               ack_o,
  output logic               ack_swi_o,
  output logic [IW-1:0]      ack_id_o,
  output logic               ie_o,
  output logic [1:0]         isp_o,
  output logic [N_SRC-1:0]   pend_o
);
  logic [N_SRC-1:0] flag, ack_clr;
  logic             m_valid, grant_m, grant_s, swi_q, ack_q, ack_swi_q;
  logic [IW-1:0]    m_idx, id_q;
  prio_t            m_prio, ceil;

  irq_req_latch #(.N_SRC(N_SRC)) u_latch (
    .clk_i, .rst_ni, .set_i(req_i), .clr_i, .ack_clr_i(ack_clr), .flag_o(flag)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .clk_i, .rst_ni, .flag_i(flag), .mask_i, .prio_i, .ceil_i(ceil),
    .valid_o(m_valid), .idx_o(m_idx), .prio_o(m_prio)
  );

  irq_nest_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .m_valid_i(m_valid), .m_prio_i(m_prio), .swi_pend_i(swi_q),
    .ei_i, .di_i, .reti_i, .retire_i, .grant_m_o(grant_m), .grant_s_o(grant_s),
    .ie_o, .isp_o, .ceil_o(ceil)
  );

  assign ack_clr = grant_m ? (N_SRC'(1) << m_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_q     <= 1'b0;
      ack_q     <= 1'b0;
      ack_swi_q <= 1'b0;
      id_q      <= '0;
    end else begin
      swi_q     <= (swi_q & ~grant_s) | swi_i;
      ack_q     <= grant_m;
      ack_swi_q <= grant_s;
      if (grant_m) id_q <= m_idx;
    end
  end

  assign ack_o     = ack_q;
  assign ack_swi_o = ack_swi_q;
  assign ack_id_o  = id_q;
  assign pend_o    = flag;

  AST_ACK_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(ie_o)); // R4
  AST_ACK_SETS_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (isp_o != ISP_IDLE)); // R2
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && ack_swi_o)); // R10
  AST_NO_ACK_ON_RETI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reti_i) |-> !(ack_o || ack_swi_o)); // R12
endmodule

// File: tb/irq_nest_arb_tb_top.sv
module irq_nest_arb_tb_top;
  localparam int N = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, clr = '0, mask = '0;
  logic [2*N-1:0] prio = '0;
  logic swi = 0, ei = 0, di = 0, reti = 0, retire = 0;
  logic ack, ack_swi, ie;
  logic [2:0] ack_id;
  logic [1:0] isp;
  logic [N-1:0] pend;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_nest_arb #(.N_SRC(N), .DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .clr_i(clr), .mask_i(mask),
    .prio_i(prio), .swi_i(swi), .ei_i(ei), .di_i(di), .reti_i(reti),
    .retire_i(retire), .ack_o(ack), .ack_swi_o(ack_swi), .ack_id_o(ack_id),
    .ie_o(ie), .isp_o(isp), .pend_o(pend)
  );

  // behavioural reference
  bit m_flag[N];
  bit m_swi, m_ie, m_hold, m_ack, m_ack_swi;
  int m_isp, m_id;
  int m_stk[$];

  function automatic int ceil_of(int s);
    if (s == 0) return 1;
    if (s == 1) return 2;
    return 3;
  endfunction

  function automatic int band_of(int p);
    if (p <= 1) return 0;
    if (p == 2) return 1;
    return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_swi = 0; m_ie = 0; m_hold = 0; m_ack = 0; m_ack_swi = 0;
      m_isp = 3; m_id = 0;
      m_stk.delete();
    end else begin
      int best, bp;
      bit room, do_s, do_m;
      best = -1; bp = 4;
      for (int i = 0; i < N; i++) begin
        int p;
        p = int'(prio[2*i +: 2]);
        if (m_flag[i] && !mask[i] && p <= ceil_of(m_isp) && p < bp) begin
          best = i; bp = p;
        end
      end
      room = m_stk.size() < D;
      do_s = m_swi && room && !reti;
      do_m = !do_s && best >= 0 && m_ie && !m_hold && !reti && room;
      m_ack = do_m;
      m_ack_swi = do_s;
      if (do_m) m_id = best;
      if (do_m || do_s) begin
        m_stk.push_back(m_isp * 2 + int'(m_ie));
        m_ie = 0;
        if (do_m) m_isp = band_of(bp);
      end else if (reti && m_stk.size() > 0) begin
        int e;
        e = m_stk.pop_back();
        m_isp = e / 2;
        m_ie = (e % 2) == 1;
      end else if (ei) m_ie = 1;
      else if (di) m_ie = 0;
      if (reti) m_hold = 1;
      else if (retire) m_hold = 0;
      for (int i = 0; i < N; i++)
        m_flag[i] = (m_flag[i] | req[i]) & !clr[i] & !(do_m && best == i);
      m_swi = (m_swi && !do_s) || swi;
    end
  end

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int mp;
      mp = 0;
      for (int i = 0; i < N; i++) mp |= int'(m_flag[i]) << i;
      chk(int'(ack), int'(m_ack), "R3 model ack_o");
      chk(int'(ack_swi), int'(m_ack_swi), "R10 model ack_swi_o");
      chk(int'(ack_id), m_id, "R8 model ack_id_o");
      chk(int'(ie), int'(m_ie), "R4 model ie_o");
      chk(int'(isp), m_isp, "R5 model isp_o");
      chk(int'(pend), mp, "R6 model pend_o");
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    req = '0; clr = '0; mask = '0; prio = '0;
    swi = 0; ei = 0; di = 0; reti = 0; retire = 0;
    tick(2);
    rst_n = 1;
  endtask

  task automatic p_ei();     ei = 1; tick(); ei = 0; endtask
  task automatic p_reti();   reti = 1; tick(); reti = 0; endtask
  task automatic p_retire(); retire = 1; tick(); retire = 0; endtask
  task automatic p_req(logic [N-1:0] v); req = v; tick(); req = '0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(int'(ie), 0, "R1 ie_o");
    chk(int'(isp), 3, "R1 isp_o");
    chk(int'(pend), 0, "R1 pend_o");
    chk(int'(ack | ack_swi), 0, "R1 acks");

    // R2 R3: single request, band mapping
    prio[2*5 +: 2] = 2'd2; prio[2*1 +: 2] = 2'd0; prio[2*6 +: 2] = 2'd3;
    p_ei();
    p_req(8'h20);
    chk(int'(pend[5]), 1, "R3 pend latch");
    tick();
    chk(int'(ack), 1, "R3 ack pulse");
    chk(int'(ack_id), 5, "R3 ack id");
    chk(int'(isp), 1, "R2 band code");
    chk(int'(ie), 0, "R3 ie cleared");
    chk(int'(pend[5]), 0, "R3 flag cleared");
    tick();
    chk(int'(ack), 0, "R3 single pulse");

    // R4 R6: enable off holds a top request
    p_req(8'h02);
    tick();
    chk(int'(ack), 0, "R4 no ack while disabled");
    chk(int'(pend[1]), 1, "R6 still pending");
    // R5: nesting a more urgent request
    p_ei();
    tick();
    chk(int'(ack), 1, "R5 nested ack");
    chk(int'(ack_id), 1, "R5 nested id");
    chk(int'(isp), 0, "R2 band 0/1 code");
    // R5: less urgent refused
    p_req(8'h40);
    p_ei();
    tick();
    chk(int'(ack), 0, "R5 lower refused");
    chk(int'(pend[6]), 1, "R6 lower kept");
    // R12 unwind
    p_reti();
    chk(int'(isp), 1, "R12 restore isp");
    chk(int'(ie), 1, "R12 restore ie");
    p_reti();
    chk(int'(isp), 3, "R12 restore idle");
    chk(int'(ie), 1, "R12 restore ie outer");
    tick(2);
    chk(int'(ack), 0, "R7 wait after return");
    p_retire();
    chk(int'(ack), 0, "R7 retire edge");
    tick();
    chk(int'(ack), 1, "R7 ack after retire");
    chk(int'(ack_id), 6, "R7 id");
    chk(int'(isp), 2, "R2 band 3 code");

    // R8 tie
    do_reset();
    prio[2*2 +: 2] = 2'd1; prio[2*3 +: 2] = 2'd1; prio[2*0 +: 2] = 2'd3;
    p_ei();
    p_req(8'h0C);
    tick();
    chk(int'(ack), 1, "R8 tie ack");
    chk(int'(ack_id), 2, "R8 lowest index");
    chk(int'(pend[3]), 1, "R8 loser pending");

    // R9 masking
    do_reset();
    mask[4] = 1;
    p_ei();
    p_req(8'h10);
    tick();
    chk(int'(ack), 0, "R9 masked ignored");
    chk(int'(pend[4]), 1, "R9 masked flag kept");
    mask[4] = 0;
    tick();
    chk(int'(ack), 1, "R9 unmasked ack");
    chk(int'(ack_id), 4, "R9 unmasked id");

    // R10 software request bypasses enable
    do_reset();
    swi = 1; tick(); swi = 0;
    tick();
    chk(int'(ack_swi), 1, "R10 swi ack");
    chk(int'(isp), 3, "R10 isp kept");
    chk(int'(ack), 0, "R10 not maskable");

    // R11 stack full
    do_reset();
    for (int k = 0; k < D; k++) begin
      p_ei();
      p_req(N'(1) << k);
      tick();
      chk(int'(ack), 1, "R11 fill ack");
      chk(int'(ack_id), k, "R11 fill id");
    end
    p_ei();
    p_req(8'h10);
    swi = 1; tick(); swi = 0;
    tick();
    chk(int'(ack), 0, "R11 full blocks maskable");
    chk(int'(ack_swi), 0, "R11 full blocks swi");
    chk(int'(pend[4]), 1, "R11 request kept");

    // R12 return on empty stack
    do_reset();
    p_ei();
    p_reti();
    chk(int'(isp), 3, "R12 empty pop isp");
    chk(int'(ie), 1, "R12 empty pop ie");

    // random phase, model-checked
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 15) == 0) prio = 16'($urandom());
      if ($urandom_range(0, 31) == 0) mask = 8'($urandom()) & 8'($urandom());
      req    = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : '0;
      clr    = ($urandom_range(0, 31) == 0) ? 8'(1 << $urandom_range(0, 7)) : '0;
      swi    = $urandom_range(0, 39) == 0;
      ei     = $urandom_range(0, 2) == 0;
      di     = $urandom_range(0, 19) == 0;
      reti   = $urandom_range(0, 11) == 0;
      retire = $urandom_range(0, 3) == 0;
      tick();
    end
    req = '0; clr = '0; swi = 0; ei = 0; di = 0; reti = 0; retire = 0;
    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule